// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the arithmetic and logic unit of a small 8-bit processor whose register R0 serves as the accumulator. Each cycle the surrounding datapath presents an operation code, the contents of the selected register Rn, the contents of the accumulator, and the current Carry and Negative flags. It also supplies a bit index for the bit-test operation. The block is purely combinational. It returns an 8-bit result together with a write enable and a destination select that says whether the result belongs in the accumulator or in Rn. It also returns a 16-bit product with a valid strobe and the next values of the Zero, Carry and Negative flags.

Every operation has a fixed implicit destination. The two-operand operations, the moves into the accumulator, clear, compare and multiply return their result to the accumulator. Increment, decrement and the two rotates work in place on Rn, and so does the move out of the accumulator. For a multiply, the datapath puts the low byte into the accumulator and the high byte into the register above it. Register storage, the status register and instruction sequencing are not part of this block.

Top module: `acc_alu`

## Requirements
- R1: The 4-bit operation code takes these values: 0 add, 1 add with carry, 2 subtract with borrow, 3 compare, 4 and, 5 or, 6 xor, 7 clear, 8 increment, 9 decrement, 10 rotate left, 11 rotate right, 12 move Rn to accumulator, 13 move accumulator to Rn, 14 multiply, 15 bit test.
- R2: Add returns acc+Rn and add with carry returns acc+Rn+c_i. Both go to the accumulator, and Carry is the carry out of bit 7.
- R3: Subtract with borrow returns acc-Rn-(1-c_i) to the accumulator. Carry is 1 when no borrow occurs and 0 when it does.
- R4: Compare returns acc-Rn to the accumulator and ignores c_i. Carry is 1 exactly when acc is greater than or equal to Rn.
- R5: And, or and xor combine the accumulator with Rn and write to the accumulator. Carry passes c_i through unchanged.
- R6: Increment and decrement write Rn±1 to Rn. After an increment, Carry is 1 only when Rn was 0xFF. After a decrement, Carry is 0 only when Rn was 0x00.
- R7: Rotate left and rotate right work through carry and write to Rn. The bit shifted out becomes Carry, and c_i fills the vacated bit.
- R8: The move to the accumulator writes Rn, the move to Rn writes the accumulator, and clear writes 0 to the accumulator. All three pass c_i through to Carry.
- R9: Multiply drives prod_o with Rn*acc and raises prod_vld_o. It writes the low byte to the accumulator and passes c_i to Carry. Zero reflects all 16 product bits and Negative reflects product bit 15.
- R10: Bit test writes nothing (wr_en_o low) and sets Zero to the inverse of accumulator bit bit_i. Carry and Negative pass c_i and n_i through.
- R11: For every 8-bit write, wr_en_o is high, Zero is 1 exactly when the result is 0, and Negative equals result bit 7. dst_acc_o is 1 when the accumulator is the target and 0 when Rn is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1) |
| rn_i | input | 8 | Selected register contents |
| acc_i | input | 8 | Accumulator contents |
| c_i | input | 1 | Current Carry flag |
| n_i | input | 1 | Current Negative flag |
| bit_i | input | 3 | Bit index for bit test |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result is to be written |
| dst_acc_o | output | 1 | 1: write accumulator, 0: write Rn |
| prod_o | output | 16 | Multiply product |
| prod_vld_o | output | 1 | Product is valid (multiply) |
| z_o | output | 1 | Next Zero flag |
| c_o | output | 1 | Next Carry flag |
| n_o | output | 1 | Next Negative flag |

## Verification
The hardest case to reach is one where the 8-bit result and the flags disagree. The main example is a multiply whose low byte is zero while the product as a whole is not, such as 0x10 times 0x10. Zero must then stay clear even though res_o is 0. The bench drives that pair directly and also drives a full-scale product with bit 15 set. For the subtract paths it uses equal operands with and without an incoming borrow, so that the result lands exactly on 0x00 in one case and wraps to 0xFF in the other. The rotates are driven with both values of the incoming carry so that the filled bit is seen to follow c_i.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W  = 8,
  parameter int BW = $clog2(W)
) (
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   rn_i,
  input  logic [W-1:0]   acc_i,
  input  logic           c_i,
  input  logic           n_i,
  input  logic [BW-1:0]  bit_i,
  output logic [W-1:0]   res_o,
  output logic           wr_en_o,
  output logic           dst_acc_o,
  output logic [2*W-1:0] prod_o,
  output logic           prod_vld_o,
  output logic           z_o,
  output logic           c_o,
  output logic           n_o
);
  localparam logic [3:0] OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_CMP  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_ZERO = 4'd7;
  localparam logic [3:0] OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_ROTL = 4'd10, OP_ROTR = 4'd11;
  localparam logic [3:0] OP_MOVA = 4'd12, OP_MOVR = 4'd13, OP_MUL  = 4'd14, OP_BTST = 4'd15;

  logic [W:0] add_w, sub_w, cmp_w, inc_w, dec_w;
  logic       add_cin, sub_bin;

  assign add_cin = (op_i == OP_ADDC) & c_i;
  assign sub_bin = ~c_i;
  assign add_w   = {1'b0, acc_i} + {1'b0, rn_i} + {{W{1'b0}}, add_cin};
  assign sub_w   = {1'b0, acc_i} - {1'b0, rn_i} - {{W{1'b0}}, sub_bin};
  assign cmp_w   = {1'b0, acc_i} - {1'b0, rn_i};
  assign inc_w   = {1'b0, rn_i} + 1'b1;
  assign dec_w   = {1'b0, rn_i} - 1'b1;
  assign prod_o  = rn_i * acc_i;
  assign prod_vld_o = (op_i == OP_MUL);

  always_comb begin
    res_o     = '0;
    wr_en_o   = 1'b1;
    dst_acc_o = 1'b1;
    c_o       = c_i;
    unique case (op_i)
      OP_ADD, OP_ADDC: begin res_o = add_w[W-1:0]; c_o = add_w[W]; end
      OP_SUBB: begin res_o = sub_w[W-1:0]; c_o = ~sub_w[W]; end
      OP_CMP:  begin res_o = cmp_w[W-1:0]; c_o = ~cmp_w[W]; end
      OP_AND:  res_o = acc_i & rn_i;
      OP_OR:   res_o = acc_i | rn_i;
      OP_XOR:  res_o = acc_i ^ rn_i;
      OP_ZERO: res_o = '0;
      OP_INC:  begin res_o = inc_w[W-1:0]; c_o = inc_w[W]; dst_acc_o = 1'b0; end
      OP_DEC:  begin res_o = dec_w[W-1:0]; c_o = ~dec_w[W]; dst_acc_o = 1'b0; end
      OP_ROTL: begin res_o = {rn_i[W-2:0], c_i}; c_o = rn_i[W-1]; dst_acc_o = 1'b0; end
      OP_ROTR: begin res_o = {c_i, rn_i[W-1:1]}; c_o = rn_i[0]; dst_acc_o = 1'b0; end
      OP_MOVA: res_o = rn_i;
      OP_MOVR: begin res_o = acc_i; dst_acc_o = 1'b0; end
      OP_MUL:  res_o = prod_o[W-1:0];
      OP_BTST: begin res_o = acc_i; wr_en_o = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_MUL) begin
      z_o = (prod_o == '0);
      n_o = prod_o[2*W-1];
    end else if (op_i == OP_BTST) begin
      z_o = ~acc_i[bit_i];
      n_o = n_i;
    end else begin
      z_o = (res_o == '0);
      n_o = res_o[W-1];
    end
  end

  always_comb begin
    if (op_i inside {OP_INC, OP_DEC, OP_ROTL, OP_ROTR, OP_MOVR})
      assert_dst_rn_R6: assert (!dst_acc_o && wr_en_o);
    if (op_i == OP_BTST)
      assert_btst_nowrite_R10: assert (!wr_en_o && c_o == c_i && n_o == n_i);
    if (op_i == OP_MUL)
      assert_mul_low_R9: assert (prod_vld_o && res_o == prod_o[W-1:0] && dst_acc_o);
    if (op_i == OP_MOVA)
      assert_mova_R8: assert (res_o == rn_i && dst_acc_o && c_o == c_i);
    if (wr_en_o && op_i != OP_MUL)
      assert_flags_R11: assert (z_o == (res_o == '0) && n_o == res_o[W-1]);
    if (op_i inside {OP_AND, OP_OR, OP_XOR})
      assert_logic_carry_R5: assert (c_o == c_i && dst_acc_o);
  end
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]  op_i;
  logic [7:0]  rn_i, acc_i;
  logic        c_i, n_i;
  logic [2:0]  bit_i;
  logic [7:0]  res_o;
  logic        wr_en_o, dst_acc_o, prod_vld_o, z_o, c_o, n_o;
  logic [15:0] prod_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  acc_alu dut_i (
    .op_i(op_i), .rn_i(rn_i), .acc_i(acc_i), .c_i(c_i), .n_i(n_i), .bit_i(bit_i),
    .res_o(res_o), .wr_en_o(wr_en_o), .dst_acc_o(dst_acc_o), .prod_o(prod_o),
    .prod_vld_o(prod_vld_o), .z_o(z_o), .c_o(c_o), .n_o(n_o)
  );

  task automatic drive(input logic [3:0] op, input logic [7:0] rn, input logic [7:0] acc,
                       input logic c, input logic n, input logic [2:0] b);
    @(negedge clk);
    op_i = op; rn_i = rn; acc_i = acc; c_i = c; n_i = n; bit_i = b;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [7:0] res, input logic wr,
                            input logic dst, input logic z, input logic c, input logic n);
    checks++;
    if (res_o !== res || wr_en_o !== wr || dst_acc_o !== dst || z_o !== z || c_o !== c || n_o !== n) begin
      failures++;
      $display("FAIL %s op=%0d: got res=%h wr=%b dst=%b z=%b c=%b n=%b, expected res=%h wr=%b dst=%b z=%b c=%b n=%b",
               req, op_i, res_o, wr_en_o, dst_acc_o, z_o, c_o, n_o, res, wr, dst, z, c, n);
    end
  endtask

  task automatic t_reset_state;
    drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0);
    expect_out("R2 reset", 8'h00, 1, 1, 1, 0, 0);
  endtask

  task automatic t_add;
    drive(4'd0, 8'h90, 8'h70, 1'b1, 1'b0, 3'd0); expect_out("R2", 8'h00, 1, 1, 1, 1, 0);
    drive(4'd0, 8'h40, 8'h40, 1'b0, 1'b0, 3'd0); expect_out("R2", 8'h80, 1, 1, 0, 0, 1);
    drive(4'd1, 8'h00, 8'hFF, 1'b1, 1'b0, 3'd0); expect_out("R2", 8'h00, 1, 1, 1, 1, 0);
    drive(4'd1, 8'h34, 8'h12, 1'b0, 1'b0, 3'd0); expect_out("R2", 8'h46, 1, 1, 0, 0, 0);
  endtask

  task automatic t_sub_cmp;
    drive(4'd2, 8'h20, 8'h50, 1'b1, 1'b0, 3'd0); expect_out("R3", 8'h30, 1, 1, 0, 1, 0);
    drive(4'd2, 8'h20, 8'h50, 1'b0, 1'b0, 3'd0); expect_out("R3", 8'h2F, 1, 1, 0, 1, 0);
    drive(4'd2, 8'h05, 8'h05, 1'b0, 1'b0, 3'd0); expect_out("R3", 8'hFF, 1, 1, 0, 0, 1);
    drive(4'd2, 8'h05, 8'h05, 1'b1, 1'b0, 3'd0); expect_out("R3", 8'h00, 1, 1, 1, 1, 0);
    drive(4'd3, 8'h20, 8'h10, 1'b1, 1'b0, 3'd0); expect_out("R4", 8'hF0, 1, 1, 0, 0, 1);
    drive(4'd3, 8'h33, 8'h33, 1'b0, 1'b0, 3'd0); expect_out("R4", 8'h00, 1, 1, 1, 1, 0);
  endtask

  task automatic t_logic;
    drive(4'd4, 8'h3C, 8'hF0, 1'b1, 1'b0, 3'd0); expect_out("R5", 8'h30, 1, 1, 0, 1, 0);
    drive(4'd5, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0); expect_out("R5", 8'h00, 1, 1, 1, 0, 0);
    drive(4'd6, 8'h55, 8'hAA, 1'b0, 1'b0, 3'd0); expect_out("R5", 8'hFF, 1, 1, 0, 0, 1);
  endtask

  task automatic t_incdec;
    drive(4'd8, 8'hFF, 8'h12, 1'b0, 1'b0, 3'd0); expect_out("R6", 8'h00, 1, 0, 1, 1, 0);
    drive(4'd8, 8'h7F, 8'h12, 1'b1, 1'b0, 3'd0); expect_out("R6", 8'h80, 1, 0, 0, 0, 1);
    drive(4'd9, 8'h01, 8'h12, 1'b0, 1'b0, 3'd0); expect_out("R6", 8'h00, 1, 0, 1, 1, 0);
    drive(4'd9, 8'h00, 8'h12, 1'b1, 1'b0, 3'd0); expect_out("R6", 8'hFF, 1, 0, 0, 0, 1);
  endtask

  task automatic t_rotate;
    drive(4'd10, 8'h81, 8'h00, 1'b0, 1'b0, 3'd0); expect_out("R7", 8'h02, 1, 0, 0, 1, 0);
    drive(4'd10, 8'h81, 8'h00, 1'b1, 1'b0, 3'd0); expect_out("R7", 8'h03, 1, 0, 0, 1, 0);
    drive(4'd11, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0); expect_out("R7", 8'h00, 1, 0, 1, 1, 0);
    drive(4'd11, 8'h02, 8'h00, 1'b1, 1'b0, 3'd0); expect_out("R7", 8'h81, 1, 0, 0, 0, 1);
  endtask

  task automatic t_moves;
    drive(4'd12, 8'h80, 8'h11, 1'b1, 1'b0, 3'd0); expect_out("R8", 8'h80, 1, 1, 0, 1, 1);
    drive(4'd13, 8'h5A, 8'h00, 1'b0, 1'b1, 3'd0); expect_out("R8", 8'h00, 1, 0, 1, 0, 0);
    drive(4'd7,  8'h5A, 8'h05, 1'b1, 1'b1, 3'd0); expect_out("R8", 8'h00, 1, 1, 1, 1, 0);
  endtask

  task automatic t_mul;
    drive(4'd14, 8'h10, 8'h10, 1'b1, 1'b0, 3'd0);
    expect_out("R9", 8'h00, 1, 1, 0, 1, 0);
    checks++;
    if (prod_o !== 16'h0100 || prod_vld_o !== 1'b1) begin
      failures++; $display("FAIL R9 prod=%h vld=%b expected 0100 1", prod_o, prod_vld_o);
    end
    drive(4'd14, 8'hFF, 8'hFF, 1'b0, 1'b0, 3'd0);
    expect_out("R9", 8'h01, 1, 1, 0, 0, 1);
    checks++;
    if (prod_o !== 16'hFE01) begin
      failures++; $display("FAIL R9 prod=%h expected FE01", prod_o);
    end
    drive(4'd14, 8'h37, 8'h00, 1'b0, 1'b1, 3'd0);
    expect_out("R9", 8'h00, 1, 1, 1, 0, 0);
    drive(4'd0, 8'h01, 8'h01, 1'b0, 1'b0, 3'd0);
    checks++;
    if (prod_vld_o !== 1'b0) begin
      failures++; $display("FAIL R9 prod_vld=%b expected 0 outside multiply", prod_vld_o);
    end
  endtask

  task automatic t_bittest;
    for (int k = 0; k < 8; k++) begin
      drive(4'd15, 8'hAA, 8'(1 << k), 1'b1, 1'b0, 3'(k));
      checks++;
      if (wr_en_o !== 1'b0 || z_o !== 1'b0 || c_o !== 1'b1 || n_o !== 1'b0) begin
        failures++;
        $display("FAIL R10 bit %0d set: wr=%b z=%b c=%b n=%b expected 0 0 1 0", k, wr_en_o, z_o, c_o, n_o);
      end
      drive(4'd15, 8'hAA, ~8'(1 << k), 1'b0, 1'b1, 3'(k));
      checks++;
      if (wr_en_o !== 1'b0 || z_o !== 1'b1 || c_o !== 1'b0 || n_o !== 1'b1) begin
        failures++;
        $display("FAIL R10 bit %0d clear: wr=%b z=%b c=%b n=%b expected 0 1 0 1", k, wr_en_o, z_o, c_o, n_o);
      end
    end
  endtask

  task automatic t_codes_R1;
    for (int o = 0; o < 16; o++) begin
      drive(4'(o), 8'h01, 8'h01, 1'b0, 1'b0, 3'd0);
      checks++;
      if (dst_acc_o !== ((o >= 8 && o <= 11) || o == 13 ? 1'b0 : 1'b1) && o != 15) begin
        failures++;
        $display("FAIL R1 code %0d dst=%b unexpected", o, dst_acc_o);
      end
    end
  endtask

  initial begin
    op_i = 0; rn_i = 0; acc_i = 0; c_i = 0; n_i = 0; bit_i = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_codes_R1();
    t_add();
    t_sub_cmp();
    t_logic();
    t_incdec();
    t_rotate();
    t_moves();
    t_mul();
    t_bittest();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule